// File: doc/BRIEF.md
# Precise-Exception Commit Buffer

A microcoded execution engine runs each multi-step macro-instruction as a short routine of micro-operations. Many of those micro-operations write registers. This block keeps the architectural register file safe from half-finished routines. Every register write goes first into a small hidden staging buffer. The architectural file changes only when the engine signals the end of the routine. At that point every staged write lands in a single clock edge. If a fault arrives first, the staged writes are thrown away, and software sees the registers exactly as they were before the routine began.

The block owns the architectural register file and gives the engine a read port. That port returns a pending staged value before the committed one, so later micro-operations in the same routine see their own earlier results. Staged writes to the same register merge into one entry. When a write would need more entries than the buffer holds, the block reports an overflow and aborts the routine.

For faults that the system can recover from, the block captures the current micro-program counter and the scratch registers when the fault arrives. After the fault has been serviced, a resume request hands that micro-state back to the engine, so the routine can continue from the point where it stopped.

Top module: `precise_commit_buf`

## Requirements
- R1: A staged write never changes the architectural register file by itself. Only an end-of-routine commit changes it, so values that are staged and then discarded never reach it.
- R2: When `rt_done` is high and there is neither a fault nor an overflow in that cycle, every staged entry is written to the architectural file at that same edge. This includes a staged write presented in the same cycle. `cmt_done` is high for the one cycle that follows, and the staging buffer is empty afterwards.
- R3: A fault (`flt` high) empties the staging buffer. The architectural file keeps the values it held before the routine, whether or not the fault is recoverable.
- R4: When `flt` and `flt_rcv` are high together, `cur_upc` and `cur_scr` are captured and appear on `rsm_upc` and `rsm_scr` from the next cycle on. A fault with `flt_rcv` low captures nothing and does not make a resume possible.
- R5: `rd_val` shows the register selected by `rd_reg` one cycle after the selection. It returns the staged value when a write to that register is pending, and the architectural value otherwise.
- R6: Repeated staged writes to the same register take up a single buffer entry, and only the last value written is committed.
- R7: The buffer holds `DEPTH` distinct registers. A staged write to an already buffered register always succeeds. A staged write to a new register while the buffer is full raises `ovf_err` for one cycle and discards the whole buffer.
- R8: A resume request made while saved micro-state exists raises `rsm_vld` for exactly the next cycle, with the saved state on `rsm_upc` and `rsm_scr`. The saved state is then used up, and a further request gives no `rsm_vld`.
- R9: When `flt` and `rt_done` are high in the same cycle, the fault wins. Nothing is committed, `cmt_done` stays low, and the buffer is discarded.
- R10: After reset every architectural register reads 0, the buffer is empty, and `cmt_done`, `ovf_err` and `rsm_vld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_we | input | 1 | Staging write strobe from a micro-operation |
| stg_reg | input | AW | Register index of the staged write |
| stg_val | input | DW | Data of the staged write |
| rd_reg | input | AW | Register index for the forwarding read |
| rd_val | output | DW | Registered read result |
| rt_done | input | 1 | Final micro-operation of the routine completes |
| flt | input | 1 | Fault raised during the routine |
| flt_rcv | input | 1 | The fault in this cycle is recoverable |
| cur_upc | input | UPCW | Current micro-program counter |
| cur_scr | input | NSCR*DW | Current scratch registers, packed |
| rsm_req | input | 1 | Request to restore the saved micro-state |
| cmt_done | output | 1 | One-cycle pulse after a commit |
| ovf_err | output | 1 | One-cycle pulse after a capacity overflow |
| rsm_vld | output | 1 | One-cycle pulse when restored state is presented |
| rsm_upc | output | UPCW | Saved micro-program counter |
| rsm_scr | output | NSCR*DW | Saved scratch registers, packed |

## Verification
The assertions assume that `flt_rcv` only has meaning together with `flt`, and that a resume request never lands in the same cycle as a fault that saves state. The directed stimulus keeps these two apart. It also changes inputs only at the falling edge, so every strobe is seen at exactly one rising edge. The invariants on the buffer (no duplicate register among valid entries, occupancy at or below `DEPTH`) hold for any input sequence. The bench drives repeated writes to the same register, and a write to a new register while the buffer is full, so that both invariants are actually stressed.

// File: rtl/cb_pkg.sv
package cb_pkg;
  typedef enum logic [1:0] {
    ACT_IDLE   = 2'd0,
    ACT_COMMIT = 2'd1,
    ACT_ABORT  = 2'd2
  } cb_act_e;
endpackage

// File: rtl/cb_stage.sv
module cb_stage
  import cb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int CW    = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_idx,
  input  logic [DW-1:0]              wr_dat,
  input  cb_act_e                    act,
  input  logic [AW-1:0]              lk_idx,
  output logic                       ovf,
  output logic                       lk_hit,
  output logic [DW-1:0]              lk_dat,
  output logic [DEPTH-1:0]           nx_vld,
  output logic [DEPTH-1:0][AW-1:0]   nx_idx,
  output logic [DEPTH-1:0][DW-1:0]   nx_dat,
  output logic [CW-1:0]              cnt
);
  logic [DEPTH-1:0]         vld_q;
  logic [DEPTH-1:0][AW-1:0] idx_q;
  logic [DEPTH-1:0][DW-1:0] dat_q;
  logic [CW-1:0]            cnt_q, nx_cnt;
  logic                     hit, full, alloc, dup;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && idx_q[i] == wr_idx) hit = 1'b1;
    full  = (cnt_q == CW'(DEPTH));
    ovf   = wr_en && !hit && full;
    alloc = wr_en && !hit && !full;
    nx_vld = vld_q;
    nx_idx = idx_q;
    nx_dat = dat_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && vld_q[i] && idx_q[i] == wr_idx) nx_dat[i] = wr_dat;
      if (alloc && CW'(i) == cnt_q) begin
        nx_vld[i] = 1'b1;
        nx_idx[i] = wr_idx;
        nx_dat[i] = wr_dat;
      end
    end
    nx_cnt = cnt_q + {{(CW-1){1'b0}}, alloc};
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_dat = '0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && idx_q[i] == lk_idx) begin
        lk_hit = 1'b1;
        lk_dat = dat_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (rst || act != ACT_IDLE) begin
      vld_q <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= nx_vld;
      cnt_q <= nx_cnt;
    end
    idx_q <= nx_idx;
    dat_q <= nx_dat;
  end

  assign cnt = cnt_q;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      for (int j = i + 1; j < DEPTH; j++)
        if (vld_q[i] && vld_q[j] && idx_q[i] == idx_q[j]) dup = 1'b1;
  end

  a_r6_single_entry_per_reg: assert property (@(posedge clk) disable iff (rst) !dup);
  a_r7_occupancy_bound: assert property (@(posedge clk) disable iff (rst) cnt_q <= CW'(DEPTH));
  a_r3_discard_empties: assert property (@(posedge clk) disable iff (rst)
    (act != ACT_IDLE) |=> (cnt_q == '0 && vld_q == '0));
endmodule

// File: rtl/cb_arch_rf.sv
module cb_arch_rf #(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cmt,
  input  logic [DEPTH-1:0]           nx_vld,
  input  logic [DEPTH-1:0][AW-1:0]   nx_idx,
  input  logic [DEPTH-1:0][DW-1:0]   nx_dat,
  input  logic [AW-1:0]              rd_idx,
  output logic [DW-1:0]              rd_arf
);
  logic [NREG-1:0][DW-1:0] rf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q <= '0;
    end else if (cmt) begin
      for (int i = 0; i < DEPTH; i++)
        if (nx_vld[i]) rf_q[nx_idx[i]] <= nx_dat[i];
    end
  end

  assign rd_arf = rf_q[rd_idx];

  a_r1_arch_only_on_commit: assert property (@(posedge clk) disable iff (rst)
    !cmt |=> $stable(rf_q));
endmodule

// File: rtl/cb_save.sv
module cb_save #(
  parameter int DW   = 32,
  parameter int UPCW = 8,
  parameter int NSCR = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 save_en,
  input  logic [UPCW-1:0]      upc,
  input  logic [NSCR*DW-1:0]   scr,
  input  logic                 rsm_req,
  output logic                 rsm_vld,
  output logic [UPCW-1:0]      rsm_upc,
  output logic [NSCR*DW-1:0]   rsm_scr
);
  logic sav_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sav_q   <= 1'b0;
      rsm_vld <= 1'b0;
      rsm_upc <= '0;
      rsm_scr <= '0;
    end else begin
      if (save_en) begin
        rsm_upc <= upc;
        rsm_scr <= scr;
      end
      if (save_en)      sav_q <= 1'b1;
      else if (rsm_req) sav_q <= 1'b0;
      rsm_vld <= rsm_req && sav_q;
    end
  end

  a_r4_saved_state_held: assert property (@(posedge clk) disable iff (rst)
    !save_en |=> ($stable(rsm_upc) && $stable(rsm_scr)));
  a_r8_resume_answers: assert property (@(posedge clk) disable iff (rst)
    (rsm_req && sav_q && !save_en) |=> (rsm_vld && !sav_q));
endmodule

// File: rtl/precise_commit_buf.sv
module precise_commit_buf
  import cb_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int UPCW  = 8,
  parameter int NSCR  = 2,
  localparam int AW   = $clog2(NREG),
  localparam int SW   = NSCR * DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stg_we,
  input  logic [AW-1:0]   stg_reg,
  input  logic [DW-1:0]   stg_val,
  input  logic [AW-1:0]   rd_reg,
  output logic [DW-1:0]   rd_val,
  input  logic            rt_done,
  input  logic            flt,
  input  logic            flt_rcv,
  input  logic [UPCW-1:0] cur_upc,
  input  logic [SW-1:0]   cur_scr,
  input  logic            rsm_req,
  output logic            cmt_done,
  output logic            ovf_err,
  output logic            rsm_vld,
  output logic [UPCW-1:0] rsm_upc,
  output logic [SW-1:0]   rsm_scr
);
  localparam int CW = $clog2(DEPTH + 1);

  cb_act_e                  act;
  logic                     ovf, lk_hit;
  logic [DW-1:0]            lk_dat, rd_arf;
  logic [DEPTH-1:0]         nx_vld;
  logic [DEPTH-1:0][AW-1:0] nx_idx;
  logic [DEPTH-1:0][DW-1:0] nx_dat;
  logic [CW-1:0]            stg_cnt;

  always_comb begin
    if (flt || ovf)   act = ACT_ABORT;
    else if (rt_done) act = ACT_COMMIT;
    else              act = ACT_IDLE;
  end

  cb_stage #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) i_stage (
    .clk(clk), .rst(rst), .wr_en(stg_we), .wr_idx(stg_reg), .wr_dat(stg_val),
    .act(act), .lk_idx(rd_reg), .ovf(ovf), .lk_hit(lk_hit), .lk_dat(lk_dat),
    .nx_vld(nx_vld), .nx_idx(nx_idx), .nx_dat(nx_dat), .cnt(stg_cnt)
  );

  cb_arch_rf #(.NREG(NREG), .DW(DW), .DEPTH(DEPTH), .AW(AW)) i_arf (
    .clk(clk), .rst(rst), .cmt(act == ACT_COMMIT),
    .nx_vld(nx_vld), .nx_idx(nx_idx), .nx_dat(nx_dat),
    .rd_idx(rd_reg), .rd_arf(rd_arf)
  );

  cb_save #(.DW(DW), .UPCW(UPCW), .NSCR(NSCR)) i_save (
    .clk(clk), .rst(rst), .save_en(flt && flt_rcv), .upc(cur_upc), .scr(cur_scr),
    .rsm_req(rsm_req), .rsm_vld(rsm_vld), .rsm_upc(rsm_upc), .rsm_scr(rsm_scr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_val   <= '0;
      cmt_done <= 1'b0;
      ovf_err  <= 1'b0;
    end else begin
      rd_val   <= lk_hit ? lk_dat : rd_arf;
      cmt_done <= (act == ACT_COMMIT);
      ovf_err  <= ovf;
    end
  end

  a_r9_fault_beats_commit: assert property (@(posedge clk) disable iff (rst)
    (flt && rt_done) |=> !cmt_done);
  a_r7_overflow_empties: assert property (@(posedge clk) disable iff (rst)
    ovf_err |-> (stg_cnt == '0));
endmodule

// File: tb/test_precise_commit_buf.sv
module test_precise_commit_buf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        stg_we, rt_done, flt, flt_rcv, rsm_req;
  logic [3:0]  stg_reg, rd_reg;
  logic [31:0] stg_val, rd_val;
  logic [7:0]  cur_upc, rsm_upc;
  logic [63:0] cur_scr, rsm_scr;
  logic        cmt_done, ovf_err, rsm_vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  precise_commit_buf i_precise_commit_buf (
    .clk(clk), .rst(rst), .stg_we(stg_we), .stg_reg(stg_reg), .stg_val(stg_val),
    .rd_reg(rd_reg), .rd_val(rd_val), .rt_done(rt_done), .flt(flt), .flt_rcv(flt_rcv),
    .cur_upc(cur_upc), .cur_scr(cur_scr), .rsm_req(rsm_req), .cmt_done(cmt_done),
    .ovf_err(ovf_err), .rsm_vld(rsm_vld), .rsm_upc(rsm_upc), .rsm_scr(rsm_scr)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic stage(input logic [3:0] r, input logic [31:0] v);
    stg_we = 1'b1; stg_reg = r; stg_val = v;
    @(negedge clk);
    stg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] r, output logic [31:0] v);
    rd_reg = r;
    @(negedge clk);
    v = rd_val;
  endtask

  task automatic pulse_end();
    rt_done = 1'b1;
    @(negedge clk);
    rt_done = 1'b0;
  endtask

  task automatic pulse_flt(input bit rcv);
    flt = 1'b1; flt_rcv = rcv;
    @(negedge clk);
    flt = 1'b0; flt_rcv = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R10 cmt_done", 64'(cmt_done), 0);
    chk("R10 ovf_err", 64'(ovf_err), 0);
    chk("R10 rsm_vld", 64'(rsm_vld), 0);
    rd(4'd5, v);
    chk("R10 reg5", 64'(v), 0);
  endtask

  task automatic t_commit();
    logic [31:0] v;
    stage(4'd1, 32'hA1A1_0001);
    stage(4'd2, 32'hB2B2_0002);
    rd(4'd1, v);  chk("R5 forward reg1", 64'(v), 64'h A1A1_0001);
    rd(4'd3, v);  chk("R5 arch reg3", 64'(v), 0);
    stg_we = 1'b1; stg_reg = 4'd4; stg_val = 32'hC4C4_0004; rt_done = 1'b1;
    @(negedge clk);
    stg_we = 1'b0; rt_done = 1'b0;
    chk("R2 cmt_done pulse", 64'(cmt_done), 1);
    rd(4'd1, v);  chk("R2 reg1", 64'(v), 64'h A1A1_0001);
    chk("R2 cmt_done one cycle", 64'(cmt_done), 0);
    rd(4'd2, v);  chk("R2 reg2", 64'(v), 64'h B2B2_0002);
    rd(4'd4, v);  chk("R2 same-cycle write reg4", 64'(v), 64'h C4C4_0004);
  endtask

  task automatic t_coalesce();
    logic [31:0] v;
    stage(4'd1, 32'd10);
    stage(4'd1, 32'd11);
    stage(4'd1, 32'd12);
    stage(4'd5, 32'd55);
    stage(4'd6, 32'd66);
    stage(4'd7, 32'd77);
    chk("R6 no overflow with merged entries", 64'(ovf_err), 0);
    rd(4'd1, v);  chk("R6 forward newest reg1", 64'(v), 12);
    pulse_end();
    rd(4'd1, v);  chk("R6 last value committed reg1", 64'(v), 12);
    rd(4'd7, v);  chk("R6 reg7", 64'(v), 77);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    stage(4'd2, 32'hDEAD_BEEF);
    stage(4'd8, 32'h0000_0088);
    rd(4'd8, v);  chk("R5 forward reg8", 64'(v), 64'h88);
    pulse_flt(1'b0);
    rd(4'd2, v);  chk("R3 reg2 unchanged", 64'(v), 64'h B2B2_0002);
    rd(4'd8, v);  chk("R1 reg8 never written", 64'(v), 0);
    pulse_end();
    rd(4'd2, v);  chk("R1 empty commit leaves reg2", 64'(v), 64'h B2B2_0002);
  endtask

  task automatic t_ovf();
    logic [31:0] v;
    stage(4'd9,  32'h99);
    stage(4'd10, 32'hAA);
    stage(4'd11, 32'hBB);
    stage(4'd12, 32'hCC);
    stage(4'd9,  32'h999);
    chk("R7 rewrite when full no overflow", 64'(ovf_err), 0);
    stage(4'd13, 32'hDD);
    chk("R7 overflow pulse", 64'(ovf_err), 1);
    rd(4'd9, v);  chk("R7 buffer discarded reg9", 64'(v), 0);
    chk("R7 overflow one cycle", 64'(ovf_err), 0);
    rd(4'd12, v); chk("R7 buffer discarded reg12", 64'(v), 0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    stage(4'd3, 32'h33);
    rt_done = 1'b1; flt = 1'b1;
    @(negedge clk);
    rt_done = 1'b0; flt = 1'b0;
    chk("R9 no commit pulse", 64'(cmt_done), 0);
    rd(4'd3, v);  chk("R9 reg3 unchanged", 64'(v), 0);
  endtask

  task automatic t_recover();
    logic [31:0] v;
    cur_upc = 8'h11; cur_scr = 64'h1111_1111_1111_1111;
    pulse_flt(1'b0);
    chk("R4 non-recoverable saves nothing", 64'(rsm_upc), 0);
    rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
    chk("R4 no resume without save", 64'(rsm_vld), 0);
    stage(4'd14, 32'hEE);
    cur_upc = 8'h5A; cur_scr = 64'h1234_5678_9ABC_DEF0;
    pulse_flt(1'b1);
    cur_upc = 8'h00; cur_scr = '0;
    chk("R4 saved upc", 64'(rsm_upc), 64'h5A);
    chk("R4 saved scratch", rsm_scr, 64'h1234_5678_9ABC_DEF0);
    rd(4'd14, v); chk("R3 recoverable fault discards reg14", 64'(v), 0);
    chk("R8 no pulse before request", 64'(rsm_vld), 0);
    rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
    chk("R8 resume valid", 64'(rsm_vld), 1);
    chk("R8 resume upc", 64'(rsm_upc), 64'h5A);
    chk("R8 resume scratch", rsm_scr, 64'h1234_5678_9ABC_DEF0);
    @(negedge clk);
    chk("R8 pulse one cycle", 64'(rsm_vld), 0);
    rsm_req = 1'b1; @(negedge clk); rsm_req = 1'b0;
    chk("R8 state used up", 64'(rsm_vld), 0);
  endtask

  initial begin
    rst = 1'b1; stg_we = 0; rt_done = 0; flt = 0; flt_rcv = 0; rsm_req = 0;
    stg_reg = '0; stg_val = '0; rd_reg = '0; cur_upc = '0; cur_scr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_commit();
    t_coalesce();
    t_abort();
    t_ovf();
    t_prio();
    t_recover();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule